// File: doc/BRIEF.md
# Relocatable RAM Overlay Window

This block sits between a bus master and a larger backing memory. It holds two local RAMs. The first is an overlay RAM whose window can be moved to any aligned spot in the address map, and switched on or off, as often as needed. The second is a main RAM whose window can be moved only once after each reset. Accesses that land in an active window are served locally. All other accesses pass to the backing-memory port.

Because overlay hits never wait on the backing memory, software can keep running from a copy of a memory region while that region is being erased or rewritten. The priority order is fixed. The overlay wins over the main RAM, and both win over the backing memory.

The bus is a simple synchronous request/ready handshake. The master holds `req_i` and the access fields steady until it sees `ready_o`. The access completes on the rising clock edge where both are high.

Top module: `overlay_window`

## Requirements
- R1: After reset the overlay is disabled, the main RAM window sits at address 0x0000 (size 1 KB), and the lock on the main-window register is clear. With no request, `ready_o` is 0.
- R2: While the overlay is enabled, any access with base ≤ address < base + 2048 is served by the overlay RAM, and `mem_req_o` stays 0. The first address past the window goes to the backing port.
- R3: The overlay base is aligned to 2 KB. The low 11 bits of `ctl_base_i` are ignored.
- R4: Clearing the overlay enable removes the window from the map, so its addresses pass through. The overlay contents are kept, and they reappear when the window is enabled again.
- R5: The overlay control register can be rewritten any number of times. A new base or enable value applies to accesses from the cycle after the write.
- R6: The main-window register accepts only the first write after reset. Later writes have no effect until the next reset. Main RAM contents are not cleared by reset.
- R7: Inside the main window, the main RAM serves the access instead of the backing memory.
- R8: Where the overlay and main windows overlap, the overlay serves the access and the main RAM is left untouched.
- R9: Overlay and main RAM accesses complete in the same cycle as the request, whatever the value of `mem_ready_i`.
- R10: Outside both windows, the request, write flag, address and write data are forwarded to the backing port. In that case `ready_o` follows `mem_ready_i` and `rdata_o` follows `mem_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ready_o | output | 1 | Access completes this cycle |
| ctl_we_i | input | 1 | Write strobe for the overlay control register |
| ctl_en_i | input | 1 | Overlay enable value to write |
| ctl_base_i | input | 16 | Overlay base to write (low 11 bits ignored) |
| map_we_i | input | 1 | Write strobe for the main-window register |
| map_base_i | input | 16 | Main window base to write (low 10 bits ignored) |
| mem_req_o | output | 1 | Backing memory request |
| mem_we_o | output | 1 | Backing memory write flag |
| mem_addr_o | output | 16 | Backing memory address |
| mem_wdata_o | output | 8 | Backing memory write data |
| mem_rdata_i | input | 8 | Backing memory read data |
| mem_ready_i | input | 1 | Backing memory ready |

## Verification
Faults in the stored base, enable or lock state show up at the ports on the first access to an affected address. Such an access raises `mem_req_o` when it should not, or returns backing data in place of RAM data, or the reverse. Every access therefore checks both the returned byte and the routing on `mem_req_o`. The sequence probes both edges of each window, the cycle right after each register write, a locked second write, and overlapping windows. A decode slip of one bit, or a lost lock, is caught within one access.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    SEL_EXT  = 2'd0,
    SEL_MAIN = 2'd1,
    SEL_OVL  = 2'd2
  } ovl_sel_e;
endpackage

// File: rtl/ovl_ram.sv
module ovl_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int RAW  = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [RAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode #(
  parameter int AW     = 16,
  parameter int WIN_AW = 11,
  localparam int BW    = AW - WIN_AW
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] base_i,
  output logic          hit_o
);
  assign hit_o = en_i && (addr_i[AW-1:WIN_AW] == base_i);
endmodule

// File: rtl/ovl_regs.sv
module ovl_regs #(
  parameter int          AW            = 16,
  parameter int          OVL_AW        = 11,
  parameter int          MAIN_AW       = 10,
  parameter logic [15:0] MAIN_RST_BASE = 16'h0000,
  localparam int         OBW           = AW - OVL_AW,
  localparam int         MBW           = AW - MAIN_AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ctl_we_i,
  input  logic           ctl_en_i,
  input  logic [AW-1:0]  ctl_base_i,
  input  logic           map_we_i,
  input  logic [AW-1:0]  map_base_i,
  output logic           ovl_en_o,
  output logic [OBW-1:0] ovl_base_o,
  output logic [MBW-1:0] main_base_o,
  output logic           lock_o
);
  // low bits only select a byte inside the window
  logic unused_low;
  assign unused_low = ^{ctl_base_i[OVL_AW-1:0], map_base_i[MAIN_AW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovl_en_o   <= 1'b0;
      ovl_base_o <= '0;
    end else if (ctl_we_i) begin
      ovl_en_o   <= ctl_en_i;
      ovl_base_o <= ctl_base_i[AW-1:OVL_AW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_base_o <= MAIN_RST_BASE[AW-1:MAIN_AW];
      lock_o      <= 1'b0;
    end else if (map_we_i && !lock_o) begin
      main_base_o <= map_base_i[AW-1:MAIN_AW];
      lock_o      <= 1'b1;
    end
  end
endmodule

// File: rtl/overlay_window.sv
module overlay_window
  import ovl_pkg::*;
#(
  parameter int          AW            = 16,
  parameter int          DW            = 8,
  parameter int          OVL_BYTES     = 2048,
  parameter int          MAIN_BYTES    = 1024,
  parameter logic [15:0] MAIN_RST_BASE = 16'h0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  input  logic          ctl_we_i,
  input  logic          ctl_en_i,
  input  logic [AW-1:0] ctl_base_i,
  input  logic          map_we_i,
  input  logic [AW-1:0] map_base_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i
);
  localparam int OVL_AW  = $clog2(OVL_BYTES);
  localparam int MAIN_AW = $clog2(MAIN_BYTES);
  localparam int OBW     = AW - OVL_AW;
  localparam int MBW     = AW - MAIN_AW;

  logic           ovl_en, lock;
  logic [OBW-1:0] ovl_base;
  logic [MBW-1:0] main_base;
  logic           ovl_hit, main_hit;
  ovl_sel_e       sel;
  logic [DW-1:0]  ovl_rdata, main_rdata;

  ovl_regs #(
    .AW(AW), .OVL_AW(OVL_AW), .MAIN_AW(MAIN_AW), .MAIN_RST_BASE(MAIN_RST_BASE)
  ) u_regs (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_en_i, .ctl_base_i, .map_we_i, .map_base_i,
    .ovl_en_o(ovl_en), .ovl_base_o(ovl_base), .main_base_o(main_base), .lock_o(lock)
  );

  ovl_decode #(.AW(AW), .WIN_AW(OVL_AW)) u_dec_ovl (
    .en_i(ovl_en), .addr_i, .base_i(ovl_base), .hit_o(ovl_hit)
  );

  ovl_decode #(.AW(AW), .WIN_AW(MAIN_AW)) u_dec_main (
    .en_i(1'b1), .addr_i, .base_i(main_base), .hit_o(main_hit)
  );

  // fixed priority: overlay, then main RAM, then backing memory
  always_comb begin
    if (ovl_hit)       sel = SEL_OVL;
    else if (main_hit) sel = SEL_MAIN;
    else               sel = SEL_EXT;
  end

  ovl_ram #(.DEPTH(OVL_BYTES), .DW(DW)) u_ovl_ram (
    .clk_i, .we_i(req_i && we_i && (sel == SEL_OVL)),
    .addr_i(addr_i[OVL_AW-1:0]), .wdata_i, .rdata_o(ovl_rdata)
  );

  ovl_ram #(.DEPTH(MAIN_BYTES), .DW(DW)) u_main_ram (
    .clk_i, .we_i(req_i && we_i && (sel == SEL_MAIN)),
    .addr_i(addr_i[MAIN_AW-1:0]), .wdata_i, .rdata_o(main_rdata)
  );

  assign mem_req_o   = req_i && (sel == SEL_EXT);
  assign mem_we_o    = we_i;
  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = wdata_i;

  always_comb begin
    unique case (sel)
      SEL_OVL:  rdata_o = ovl_rdata;
      SEL_MAIN: rdata_o = main_rdata;
      default:  rdata_o = mem_rdata_i;
    endcase
  end

  assign ready_o = req_i && ((sel != SEL_EXT) || mem_ready_i);
endmodule

// File: rtl/ovl_window_chk.sv
module ovl_window_chk #(
  parameter int MBW = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           ready_o,
  input logic           mem_req_o,
  input logic           mem_ready_i,
  input logic           ctl_we_i,
  input logic           ctl_en_i,
  input logic           ovl_en,
  input logic           ovl_hit,
  input logic           main_hit,
  input logic           lock,
  input logic [MBW-1:0] main_base
);
  p_local_fast_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (ovl_hit || main_hit) |-> ready_o && !mem_req_o);

  p_ext_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (ready_o == mem_ready_i));

  p_ctl_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (ovl_en == $past(ctl_en_i)));

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> lock && $stable(main_base));

  p_off_no_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovl_en |-> !ovl_hit);

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !ready_o && !mem_req_o);
endmodule

bind overlay_window ovl_window_chk #(.MBW(MBW)) u_chk (
  .clk_i, .rst_ni, .req_i, .ready_o, .mem_req_o, .mem_ready_i, .ctl_we_i,
  .ctl_en_i, .ovl_en, .ovl_hit, .main_hit, .lock, .main_base
);

// File: tb/overlay_window_bench.sv
module overlay_window_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0, rdata_o;
  logic        ready_o;
  logic        ctl_we_i = 1'b0, ctl_en_i = 1'b0;
  logic [15:0] ctl_base_i = '0;
  logic        map_we_i = 1'b0;
  logic [15:0] map_base_i = '0;
  logic        mem_req_o, mem_we_o, mem_ready_i;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        mem_busy = 1'b0;

  int run_cnt = 0, fail_cnt = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // backing memory model: data is a function of the address
  assign mem_rdata_i = mem_addr_o[7:0] ^ 8'h3C;
  assign mem_ready_i = !mem_busy;

  overlay_window u_overlay_window (.*);

  function automatic logic [7:0] ext_val(input logic [15:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    run_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected byte for each completing read
  always @(negedge clk_i) begin
    if (rst_ni && req_i && !we_i && ready_o) begin
      if (exp_q.size() == 0) check("scoreboard-empty", 16'h1, 16'h0);
      else check(tag_q.pop_front(), {8'h0, rdata_o}, {8'h0, exp_q.pop_front()});
    end
  end

  task automatic acc(input logic w, input logic [15:0] a, input logic [7:0] d,
                     input logic [7:0] exp, input logic ext, input string tag);
    @(posedge clk_i); #1;
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    if (!w) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    do @(negedge clk_i); while (!ready_o);
    check({tag, " route"}, {15'h0, mem_req_o}, {15'h0, ext});
    if (w && ext) begin
      check({tag, " fwd-addr"}, mem_addr_o, a);
      check({tag, " fwd-data"}, {8'h0, mem_wdata_o}, {8'h0, d});
      check({tag, " fwd-we"}, {15'h0, mem_we_o}, 16'h1);
    end
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic set_ctl(input logic en, input logic [15:0] b);
    idle();
    ctl_we_i = 1'b1; ctl_en_i = en; ctl_base_i = b;
    @(posedge clk_i); #1;
    ctl_we_i = 1'b0;
  endtask

  task automatic set_map(input logic [15:0] b);
    idle();
    map_we_i = 1'b1; map_base_i = b;
    @(posedge clk_i); #1;
    map_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fail_cnt++; run_cnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", run_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: idle after reset
    check("R1 idle ready", {15'h0, ready_o}, 16'h0);
    check("R1 idle mem_req", {15'h0, mem_req_o}, 16'h0);
    acc(0, 16'h4005, 0, ext_val(16'h4005), 1, "R1 overlay off");
    acc(0, 16'h0800, 0, ext_val(16'h0800), 1, "R10 pass read");
    // R7: main RAM at 0x0000
    acc(1, 16'h0010, 8'h5A, 0, 0, "R7 main write");
    acc(0, 16'h0010, 0, 8'h5A, 0, "R7 main read");
    acc(0, 16'h0400, 0, ext_val(16'h0400), 1, "R7 main end");
    // R3/R5: misaligned base, used the very next cycle
    set_ctl(1, 16'h4123);
    acc(1, 16'h4005, 8'h77, 0, 0, "R5 next-cycle write");
    acc(0, 16'h4005, 0, 8'h77, 0, "R3 aligned read");
    acc(1, 16'h47FF, 8'h11, 0, 0, "R2 top write");
    acc(0, 16'h47FF, 0, 8'h11, 0, "R2 top read");
    acc(0, 16'h4800, 0, ext_val(16'h4800), 1, "R2 past top");
    acc(0, 16'h3FFF, 0, ext_val(16'h3FFF), 1, "R2 below base");
    // R9: backing memory busy
    idle(); mem_busy = 1'b1;
    acc(0, 16'h4005, 0, 8'h77, 0, "R9 overlay busy");
    acc(0, 16'h0010, 0, 8'h5A, 0, "R9 main busy");
    @(posedge clk_i); #1;
    addr_i = 16'h5000; we_i = 1'b0; req_i = 1'b1;
    exp_q.push_back(ext_val(16'h5000)); tag_q.push_back("R10 stall read");
    @(negedge clk_i);
    check("R10 stall ready", {15'h0, ready_o}, 16'h0);
    @(negedge clk_i);
    check("R10 stall ready 2", {15'h0, ready_o}, 16'h0);
    #1 mem_busy = 1'b0;
    @(negedge clk_i);
    check("R10 released", {15'h0, ready_o}, 16'h1);
    // R4: disable and re-enable
    set_ctl(0, 16'h4000);
    acc(0, 16'h4005, 0, ext_val(16'h4005), 1, "R4 disabled");
    set_ctl(1, 16'h4000);
    acc(0, 16'h4005, 0, 8'h77, 0, "R4 re-enabled");
    // R5: move window
    set_ctl(1, 16'h8000);
    acc(0, 16'h8005, 0, 8'h77, 0, "R5 moved");
    acc(0, 16'h4005, 0, ext_val(16'h4005), 1, "R5 old spot");
    // R6: write-once main map
    set_map(16'h2000);
    acc(0, 16'h2010, 0, 8'h5A, 0, "R6 first map");
    acc(0, 16'h0010, 0, ext_val(16'h0010), 1, "R6 old spot");
    set_map(16'h3000);
    acc(0, 16'h2010, 0, 8'h5A, 0, "R6 second ignored");
    acc(0, 16'h3010, 0, ext_val(16'h3010), 1, "R6 no new spot");
    // R8: overlay over main
    set_ctl(1, 16'h2000);
    acc(1, 16'h2010, 8'hE1, 0, 0, "R8 overlap write");
    acc(0, 16'h2010, 0, 8'hE1, 0, "R8 overlay wins");
    set_ctl(0, 16'h2000);
    acc(0, 16'h2010, 0, 8'h5A, 0, "R8 main untouched");
    // R10: forwarded write
    acc(1, 16'h9000, 8'h44, 0, 1, "R10 pass write");
    // R6: reset reopens the lock, RAM kept
    idle();
    rst_ni = 1'b0;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    acc(0, 16'h0010, 0, 8'h5A, 0, "R6 reset base kept data");
    set_map(16'h6000);
    acc(0, 16'h6010, 0, 8'h5A, 0, "R6 map after reset");
    idle();
    repeat (2) @(posedge clk_i);
    check("scoreboard drained", exp_q.size(), 16'h0);
    $display("[TB] %0d tests run, %0d failed", run_cnt, fail_cnt);
    $finish;
  end
endmodule